// File: doc/BRIEF.md
# Split Carry-Compression Carry-Select Adder

This block adds two unsigned binary words and a carry-in, and returns a sum word and a carry-out. The word is cut into a low field of `LOW_W` bits and a high field of `HIGH_W` bits. In the low field, a chain of two-bit carry-compression cells works out only the carries, two bit positions at a time. A separate row of two-bit sum cells takes the carry for each bit pair from that chain and forms the low sum bits.

The carry leaving the low field drives the high field. The high field is a row of per-bit carry-select cells. Each cell prepares its sum and carry for both values of the incoming carry, and the arriving carry picks one of them.

The `REG_OUT` parameter chooses between two variants. In the combinational variant the result follows the operands directly. In the registered variant the result is captured on the rising clock edge and cleared by a synchronous, active-high reset. A parameter set with an odd or zero `LOW_W`, or a zero `HIGH_W`, stops elaboration.

Top module: `sccs_adder`

## Requirements
- R1: In the combinational variant (`REG_OUT`=0) with `LOW_W`=8 and `HIGH_W`=24, `{cout, sum}` equals `opA + opB + cin` as a 33-bit unsigned value for every input.
- R2: When every bit pair of the low field propagates and `cin` is 1, the carry crosses into the high field, so that `sum[LOW_W]` equals `opA[LOW_W] ^ opB[LOW_W] ^ 1`.
- R3: All-ones plus one with `cin`=0 gives `sum`=0 and `cout`=1. Zero plus zero with `cin`=0 gives `sum`=0 and `cout`=0.
- R4: Setting `cin` to 1 adds exactly one to the result compared with `cin`=0 for the same operands.
- R5: In the registered variant with `LOW_W`=16 and `HIGH_W`=112, `{cout, sum}` equals the sum of the operands and `cin` that were present at the previous rising edge.
- R6: In the registered variant the outputs change only at a rising clock edge. After the operands change between edges, the outputs keep their old value until the next edge.
- R7: In the registered variant, a rising edge with `rst`=1 sets `sum` to 0 and `cout` to 0.
- R8: The smallest legal configuration (`LOW_W`=2, `HIGH_W`=2, combinational) gives the correct 5-bit result for all 512 combinations of operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high clear of the result register |
| opA | input | LOW_W+HIGH_W | First operand |
| opB | input | LOW_W+HIGH_W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | LOW_W+HIGH_W | Sum word |
| cout | output | 1 | Carry out of the top bit |

## Verification
The adder is driven with several kinds of input:
- **Zero plus zero** shows that no cell invents a carry.
- **All-ones plus one**, and all-ones plus a carry-in, show that a carry can run the full word length through both fields.
- **Operands with a propagating low field** separate a correct low-to-high handoff from a broken one, because only the compression chain can carry the borrow-free ripple across the field boundary.
- **Alternating patterns with and without carry-in**, together with random words, catch cells whose generate and propagate terms are swapped or whose select sense is inverted.

The tiny 4-bit configuration is swept exhaustively. The wide 128-bit registered configuration checks the results, the one-edge latency and the reset clearing.

// File: rtl/sccs_pkg.sv
package sccs_pkg;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobes_t;

endpackage

// File: rtl/sccs_low_carry.sv
module sccs_low_carry #(
  parameter int LOW_W = 8
) (
  input  logic [LOW_W-1:0]   a,
  input  logic [LOW_W-1:0]   b,
  input  logic               cin,
  output logic [LOW_W/2:0]   pairCarry
);
  localparam int PAIRS = LOW_W / 2;

  assign pairCarry[0] = cin;

  for (genvar i = 0; i < PAIRS; i++) begin : g_cc
    logic gLo, pLo, gHi, pHi, gPair, pPair;
    assign gLo   = a[2*i] & b[2*i];
    assign pLo   = a[2*i] ^ b[2*i];
    assign gHi   = a[2*i+1] & b[2*i+1];
    assign pHi   = a[2*i+1] ^ b[2*i+1];
    assign gPair = gHi | (pHi & gLo);
    assign pPair = pHi & pLo;
    assign pairCarry[i+1] = gPair | (pPair & pairCarry[i]);
  end

endmodule

// File: rtl/sccs_low_sum.sv
module sccs_low_sum #(
  parameter int LOW_W = 8
) (
  input  logic [LOW_W-1:0]   a,
  input  logic [LOW_W-1:0]   b,
  input  logic [LOW_W/2-1:0] pairCarryIn,
  output logic [LOW_W-1:0]   sum
);
  localparam int PAIRS = LOW_W / 2;

  for (genvar i = 0; i < PAIRS; i++) begin : g_so
    logic pLo, gLo, pHi, midCarry;
    assign pLo      = a[2*i] ^ b[2*i];
    assign gLo      = a[2*i] & b[2*i];
    assign pHi      = a[2*i+1] ^ b[2*i+1];
    assign midCarry = gLo | (pLo & pairCarryIn[i]);
    assign sum[2*i]   = pLo ^ pairCarryIn[i];
    assign sum[2*i+1] = pHi ^ midCarry;
  end

endmodule

// File: rtl/sccs_high_select.sv
module sccs_high_select #(
  parameter int HIGH_W = 24
) (
  input  logic [HIGH_W-1:0] a,
  input  logic [HIGH_W-1:0] b,
  input  logic              cin,
  output logic [HIGH_W-1:0] sum,
  output logic              cout
);
  logic [HIGH_W:0] selCarry;

  assign selCarry[0] = cin;

  for (genvar i = 0; i < HIGH_W; i++) begin : g_csa
    logic sumIfZero, sumIfOne, carryIfZero, carryIfOne;
    assign sumIfZero   = a[i] ^ b[i];
    assign sumIfOne    = ~(a[i] ^ b[i]);
    assign carryIfZero = a[i] & b[i];
    assign carryIfOne  = a[i] | b[i];
    assign sum[i]        = selCarry[i] ? sumIfOne : sumIfZero;
    assign selCarry[i+1] = selCarry[i] ? carryIfOne : carryIfZero;
  end

  assign cout = selCarry[HIGH_W];

endmodule

// File: rtl/sccs_datapath.sv
module sccs_datapath
  import sccs_pkg::*;
#(
  parameter int LOW_W   = 8,
  parameter int HIGH_W  = 24,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                    clk,
  input  ctrlStrobes_t            strobes,
  input  logic [LOW_W+HIGH_W-1:0] opA,
  input  logic [LOW_W+HIGH_W-1:0] opB,
  input  logic                    cin,
  output logic [LOW_W+HIGH_W-1:0] sum,
  output logic                    cout
);
  localparam int N     = LOW_W + HIGH_W;
  localparam int PAIRS = LOW_W / 2;

  logic [PAIRS:0]  pairCarry;
  logic [N-1:0]    sumComb;
  logic            coutComb;
  logic [N-1:0]    sumQ;
  logic            coutQ;

  sccs_low_carry #(.LOW_W(LOW_W)) lowCarry_i (
    .a         (opA[LOW_W-1:0]),
    .b         (opB[LOW_W-1:0]),
    .cin       (cin),
    .pairCarry (pairCarry)
  );

  sccs_low_sum #(.LOW_W(LOW_W)) lowSum_i (
    .a           (opA[LOW_W-1:0]),
    .b           (opB[LOW_W-1:0]),
    .pairCarryIn (pairCarry[PAIRS-1:0]),
    .sum         (sumComb[LOW_W-1:0])
  );

  sccs_high_select #(.HIGH_W(HIGH_W)) highSel_i (
    .a    (opA[N-1:LOW_W]),
    .b    (opB[N-1:LOW_W]),
    .cin  (pairCarry[PAIRS]),
    .sum  (sumComb[N-1:LOW_W]),
    .cout (coutComb)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      sumQ  <= '0;
      coutQ <= 1'b0;
    end else if (strobes.capture) begin
      sumQ  <= sumComb;
      coutQ <= coutComb;
    end
  end

  assign sum  = REG_OUT ? sumQ  : sumComb;
  assign cout = REG_OUT ? coutQ : coutComb;

endmodule

// File: rtl/sccs_ctrl.sv
module sccs_ctrl
  import sccs_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic         rst,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clear   = rst;
    strobes.capture = REG_OUT;
  end
endmodule

// File: rtl/sccs_adder.sv
module sccs_adder
  import sccs_pkg::*;
#(
  parameter int LOW_W   = 8,
  parameter int HIGH_W  = 24,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LOW_W+HIGH_W-1:0] opA,
  input  logic [LOW_W+HIGH_W-1:0] opB,
  input  logic                    cin,
  output logic [LOW_W+HIGH_W-1:0] sum,
  output logic                    cout
);
  if ((LOW_W < 2) || (LOW_W % 2 != 0) || (HIGH_W < 1)) begin : g_badParams
    $error("sccs_adder: LOW_W must be even and >= 2, HIGH_W must be >= 1");
  end

  ctrlStrobes_t strobes;

  sccs_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .rst     (rst),
    .strobes (strobes)
  );

  sccs_datapath #(
    .LOW_W   (LOW_W),
    .HIGH_W  (HIGH_W),
    .REG_OUT (REG_OUT)
  ) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout)
  );

endmodule

// File: rtl/sccs_adder_chk.sv
module sccs_adder_chk #(
  parameter int LOW_W   = 8,
  parameter int HIGH_W  = 24,
  parameter bit REG_OUT = 1'b0
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LOW_W+HIGH_W-1:0] opA,
  input logic [LOW_W+HIGH_W-1:0] opB,
  input logic                    cin,
  input logic [LOW_W+HIGH_W-1:0] sum,
  input logic                    cout
);
  localparam int N = LOW_W + HIGH_W;

  // R1
  comb_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!REG_OUT) |-> ({cout, sum} == ({1'b0, opA} + {1'b0, opB} + {{N{1'b0}}, cin})));

  // R2
  boundary_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ((!REG_OUT) && cin && (&(opA[LOW_W-1:0] ^ opB[LOW_W-1:0])))
      |-> (sum[LOW_W] == ~(opA[LOW_W] ^ opB[LOW_W])));

  // R3
  all_ones_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ((!REG_OUT) && (&opA) && (opB == N'(1)) && !cin) |-> (cout && (sum == '0)));

  // R5
  reg_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && !$past(rst)) |->
      ({cout, sum} == ({1'b0, $past(opA)} + {1'b0, $past(opB)} + {{N{1'b0}}, $past(cin)})));

  // R7
  reg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && $fell(rst)) |-> ((sum == '0) && !cout));

endmodule

bind sccs_adder sccs_adder_chk #(
  .LOW_W   (LOW_W),
  .HIGH_W  (HIGH_W),
  .REG_OUT (REG_OUT)
) chk_i (
  .clk  (clk),
  .rst  (rst),
  .opA  (opA),
  .opB  (opB),
  .cin  (cin),
  .sum  (sum),
  .cout (cout)
);

// File: tb/sccs_adder_tb_top.sv
`timescale 1ns/1ps
module sccs_adder_tb_top;

  localparam real CLK_HALF = 10.0;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        c;
    logic [32:0] e;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00000000, 32'h00000000, 1'b0, 33'h000000000},
    '{32'hFFFFFFFF, 32'h00000001, 1'b0, 33'h100000000},
    '{32'hFFFFFFFF, 32'h00000000, 1'b1, 33'h100000000},
    '{32'h000000FF, 32'h00000001, 1'b0, 33'h000000100},
    '{32'h000000FF, 32'h00000000, 1'b1, 33'h000000100},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 33'h1FFFFFFFF},
    '{32'h12345678, 32'h87654321, 1'b0, 33'h099999999},
    '{32'h80000000, 32'h80000000, 1'b0, 33'h100000000},
    '{32'h0000007F, 32'h00000080, 1'b1, 33'h000000100},
    '{32'hFFFFFF00, 32'h000000FF, 1'b1, 33'h100000000},
    '{32'hAAAAAAAA, 32'h55555555, 1'b0, 33'h0FFFFFFFF},
    '{32'hAAAAAAAA, 32'h55555555, 1'b1, 33'h100000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [31:0]  aM = '0, bM = '0;
  logic         cM = 1'b0;
  logic [31:0]  sM;
  logic         coM;

  logic [3:0]   aT = '0, bT = '0;
  logic         cT = 1'b0;
  logic [3:0]   sT;
  logic         coT;

  logic [127:0] aW = '0, bW = '0;
  logic         cW = 1'b0;
  logic [127:0] sW;
  logic         coW;

  int vecCount  = 0;
  int failCount = 0;
  bit done      = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  sccs_adder #(.LOW_W(8), .HIGH_W(24), .REG_OUT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .opA(aM), .opB(bM), .cin(cM), .sum(sM), .cout(coM));

  sccs_adder #(.LOW_W(2), .HIGH_W(2), .REG_OUT(1'b0)) dutTiny_i (
    .clk(clk), .rst(rst), .opA(aT), .opB(bT), .cin(cT), .sum(sT), .cout(coT));

  sccs_adder #(.LOW_W(16), .HIGH_W(112), .REG_OUT(1'b1)) dutWide_i (
    .clk(clk), .rst(rst), .opA(aW), .opB(bW), .cin(cW), .sum(sW), .cout(coW));

  task automatic checkRes(input string req, input logic [128:0] act, input logic [128:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic wideApply(input logic [127:0] a, input logic [127:0] b, input logic c, input string req);
    @(negedge clk);
    aW = a; bW = b; cW = c;
    @(negedge clk);
    checkRes(req, {coW, sW}, {1'b0, a} + {1'b0, b} + {128'b0, c});
  endtask

  initial begin
    logic [32:0]  refNoCin;
    logic [128:0] oldW;

    // R7: result register reads zero while reset is held
    repeat (2) @(negedge clk);
    checkRes("R7 reset state", {coW, sW}, '0);
    rst = 1'b0;

    // R1 R2 R3 R4: table of directed vectors
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      aM = VECS[i].a; bM = VECS[i].b; cM = VECS[i].c;
      #1;
      checkRes("R1 table vector", {coM, sM}, VECS[i].e);
    end

    // R3: the two named corner cases once more, by name
    @(negedge clk); aM = '1; bM = 32'd1; cM = 1'b0; #1;
    checkRes("R3 all-ones plus one", {coM, sM}, 33'h100000000);
    @(negedge clk); aM = '0; bM = '0; cM = 1'b0; #1;
    checkRes("R3 zero plus zero", {coM, sM}, 33'h0);

    // R2: low field all-propagate with carry-in, high bits varied
    for (int i = 0; i < 20; i++) begin
      logic [31:0] x;
      x = $urandom;
      @(negedge clk);
      aM = x; bM = {~x[31:8] ^ 24'($urandom), ~x[7:0]}; cM = 1'b1;
      #1;
      checkRes("R2 boundary carry", {coM, sM}, {1'b0, aM} + {1'b0, bM} + 33'd1);
    end

    // R4: carry-in adds exactly one
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      aM = $urandom; bM = $urandom; cM = 1'b0;
      #1;
      refNoCin = {coM, sM};
      @(negedge clk);
      cM = 1'b1;
      #1;
      checkRes("R4 carry-in adds one", {coM, sM}, refNoCin + 33'd1);
    end

    // R1: random operands
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      aM = $urandom; bM = $urandom; cM = 1'($urandom);
      #1;
      checkRes("R1 random", {coM, sM}, {1'b0, aM} + {1'b0, bM} + {32'b0, cM});
    end

    // R8: exhaustive sweep of the smallest configuration
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      aT = i[3:0]; bT = i[7:4]; cT = i[8];
      #1;
      checkRes("R8 exhaustive", {124'b0, coT, sT}, {124'b0, {1'b0, aT} + {1'b0, bT} + {4'b0, cT}});
    end

    // R5: wide registered variant, directed and random
    wideApply('1, 128'd1, 1'b0, "R5 all-ones plus one");
    wideApply('0, '0, 1'b0, "R5 zero plus zero");
    wideApply(128'h0000FFFF, 128'd0, 1'b1, "R5 boundary carry");
    wideApply('1, '1, 1'b1, "R5 all-ones both plus cin");
    for (int i = 0; i < 200; i++) begin
      wideApply(rand128(), rand128(), 1'($urandom), "R5 random");
    end

    // R6: outputs hold between edges, update at the next edge
    wideApply(128'h1234, 128'h1, 1'b0, "R6 setup");
    oldW = {coW, sW};
    @(negedge clk);
    aW = '1; bW = 128'd5; cW = 1'b0;
    #2;
    checkRes("R6 hold before edge", {coW, sW}, oldW);
    @(negedge clk);
    checkRes("R6 update after edge", {coW, sW}, 129'h100000000000000000000000000000004);

    // R7: synchronous clear during operation
    aW = '1; bW = '1; cW = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    #2;
    checkRes("R7 clear waits for edge", {coW, sW}, {1'b1, {128{1'b1}}});
    @(negedge clk);
    checkRes("R7 clear after edge", {coW, sW}, '0);
    rst = 1'b0;
    @(negedge clk);
    checkRes("R5 resume after clear", {coW, sW}, {1'b1, {128{1'b1}}});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule